// File: doc/BRIEF.md
# Descriptor-Driven DMA Transfer Engine

This block is a single-channel copy engine that works from a control entry kept in ordinary memory. The entry is three 32-bit words at a word-aligned base address. The first two words are pointers to the last byte of the source and destination regions. The third is a control word that holds the mode, the item size, the step per item, the group length and the number of items left.

When a request arrives, the engine reads the entry and derives each item's address backwards from the end pointers and the remaining count. It then copies items through one memory port, with a read followed by a write for each item. After every group of items it writes the updated control word back to the entry, giving up the port between groups. When the last item has moved, the control word goes back with the mode cleared to stop.

Two run modes are supported. Basic mode copies only while the request is held. Auto mode runs to the end from a single request pulse. An entry that cannot be executed raises an error flag and moves nothing.

Top module: `dma_desc_engine`

## Requirements
- R1: While reset is held and right after it, busy_o, done_o, err_o and mem_req_o are all low.
- R2: In idle, a high req_i starts a fetch. The engine reads three 32-bit words (mem_size_o = 2) at base_i, base_i+4 and base_i+8: source end pointer, destination end pointer, then the control word. Control word fields: mode [2:0], items minus one [13:4], group exponent [17:14], source size [25:24], source step [27:26], destination size [29:28], destination step [31:30]. Size and step codes 0, 1 and 2 mean 1, 2 and 4 bytes; step code 3 means a fixed address.
- R3: With r items remaining and step code c below 3, the item address is end − ((r−1) << c), with the low bits cleared to the item size. Step code 3 uses the end pointer itself. Items are copied in ascending order, each as a read of the source followed by a write of the same size to the destination.
- R4: With mode 2 (auto), one request cycle completes the whole transfer, including any re-fetches between groups, whatever req_i does afterwards.
- R5: With mode 1 (basic), each accepted request moves at least one item. Further items follow only while req_i is high. When the engine stops early, it writes back the control word with the count reduced by the items moved and the mode unchanged.
- R6: After each group of 2^g items (g is the group exponent; values above 10 act as 10), and at the end of the transfer, the control word is written to base_i+8. Every field other than mode and count keeps its value.
- R7: When the last item has moved, the write-back carries mode 0 and count field 0. done_o is high for exactly that write cycle.
- R8: Any of the following raises err_o and causes no item access and no write-back: mode 3 to 7, size code 3, source size different from destination size, or a step code other than 3 that is smaller than its size code. err_o stays high until the next request is accepted.
- R9: An entry with mode 0 ends the fetch with no writes and no error.
- R10: The count field covers 1 item (field 0) through 1024 items (field 1023).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request |
| base_i | input | AW | Word-aligned address of the control entry |
| busy_o | output | 1 | Engine not idle |
| done_o | output | 1 | One-cycle pulse on the final write-back |
| err_o | output | 1 | Entry could not be executed |
| mem_req_o | output | 1 | Memory access valid this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Byte address |
| mem_size_o | output | 2 | Access size code (0 byte, 1 halfword, 2 word) |
| mem_wdata_o | output | 32 | Write data, item in the low bytes |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the read |

## Verification
The assertions assume the following about the inputs: base_i is word aligned and stays constant while the engine is busy, the memory returns read data exactly one cycle after a read, and the entry is not altered while a transfer is running. The stimulus keeps base_i fixed and aligned. It places the source and destination regions apart from each other and from the entry. The memory model answers every read on the following cycle. The random transfers pick only legal step codes that are at least the item size, and the illegal encodings are applied only in directed cases.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;
  parameter int CNT_W   = 10;  // items-minus-one field width
  parameter int DW      = 32;
  parameter int GRP_MAX = CNT_W;

  typedef struct packed {
    logic [1:0]       dinc;
    logic [1:0]       dsize;
    logic [1:0]       sinc;
    logic [1:0]       ssize;
    logic [5:0]       rsvd;
    logic [3:0]       grp_exp;
    logic [CNT_W-1:0] rem_m1;
    logic             burst;
    logic [2:0]       mode;
  } ctl_t;

  localparam logic [2:0] MODE_STOP  = 3'd0;
  localparam logic [2:0] MODE_BASIC = 3'd1;
  localparam logic [2:0] MODE_AUTO  = 3'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_FSRC, S_FDST, S_FCTL, S_DEC, S_CHK, S_RD, S_WR, S_WB
  } state_t;
endpackage

// File: rtl/dma_desc_decode.sv
module dma_desc_decode
  import dma_desc_pkg::*;
(
  input  ctl_t             ctl_i,
  output logic             legal_o,
  output logic             stop_o,
  output logic             auto_o,
  output logic [CNT_W-1:0] grp_m1_o
);
  logic [3:0]     exp_c;
  logic [CNT_W:0] grp_len;
  logic [CNT_W:0] grp_m1_w;

  always_comb begin
    stop_o  = (ctl_i.mode == MODE_STOP);
    auto_o  = (ctl_i.mode == MODE_AUTO);
    legal_o = ((ctl_i.mode == MODE_BASIC) || (ctl_i.mode == MODE_AUTO)) &&
              (ctl_i.ssize != 2'd3) && (ctl_i.ssize == ctl_i.dsize) &&
              ((ctl_i.sinc == 2'd3) || (ctl_i.sinc >= ctl_i.ssize)) &&
              ((ctl_i.dinc == 2'd3) || (ctl_i.dinc >= ctl_i.dsize));
    exp_c    = (ctl_i.grp_exp > 4'(GRP_MAX)) ? 4'(GRP_MAX) : ctl_i.grp_exp;
    grp_len  = (CNT_W+1)'(1) << exp_c;
    grp_m1_w = grp_len - (CNT_W+1)'(1);
    grp_m1_o = grp_m1_w[CNT_W-1:0];
  end
endmodule

// File: rtl/dma_desc_addr.sv
module dma_desc_addr
  import dma_desc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]    end_i,
  input  logic [1:0]       inc_i,
  input  logic [1:0]       size_i,
  input  logic [CNT_W-1:0] rem_m1_i,
  output logic [AW-1:0]    addr_o
);
  logic [AW-1:0] back, raw, keep;

  always_comb begin
    back   = AW'(rem_m1_i) << inc_i;
    raw    = (inc_i == 2'd3) ? end_i : end_i - back;
    keep   = ~((AW'(1) << size_i) - AW'(1));
    addr_o = raw & keep;
  end
endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
  import dma_desc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] base_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_size_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int NSIDE = 2;  // 0 source, 1 destination

  state_t           st_q;
  logic [AW-1:0]    src_end_q, dst_end_q;
  ctl_t             ctl_q, wb_word;
  logic             last_q, err_q;
  logic [CNT_W-1:0] grp_q;

  logic             legal, is_stop, is_auto;
  logic [CNT_W-1:0] grp_m1;

  logic [AW-1:0]    side_end  [NSIDE];
  logic [1:0]       side_inc  [NSIDE];
  logic [1:0]       side_size [NSIDE];
  logic [AW-1:0]    side_addr [NSIDE];

  dma_desc_decode u_dec (
    .ctl_i    (ctl_q),
    .legal_o  (legal),
    .stop_o   (is_stop),
    .auto_o   (is_auto),
    .grp_m1_o (grp_m1)
  );

  assign side_end[0]  = src_end_q;
  assign side_end[1]  = dst_end_q;
  assign side_inc[0]  = ctl_q.sinc;
  assign side_inc[1]  = ctl_q.dinc;
  assign side_size[0] = ctl_q.ssize;
  assign side_size[1] = ctl_q.dsize;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_desc_addr #(.AW(AW)) u_addr (
      .end_i    (side_end[g]),
      .inc_i    (side_inc[g]),
      .size_i   (side_size[g]),
      .rem_m1_i (ctl_q.rem_m1),
      .addr_o   (side_addr[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      src_end_q <= '0;
      dst_end_q <= '0;
      ctl_q     <= '0;
      last_q    <= 1'b0;
      err_q     <= 1'b0;
      grp_q     <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_i) begin
          st_q  <= S_FSRC;
          err_q <= 1'b0;
        end
        S_FSRC: st_q <= S_FDST;
        S_FDST: begin
          src_end_q <= mem_rdata_i[AW-1:0];
          st_q      <= S_FCTL;
        end
        S_FCTL: begin
          dst_end_q <= mem_rdata_i[AW-1:0];
          st_q      <= S_DEC;
        end
        S_DEC: begin
          ctl_q  <= ctl_t'(mem_rdata_i);
          grp_q  <= '0;
          last_q <= 1'b0;
          st_q   <= S_CHK;
        end
        S_CHK: begin
          if (is_stop) st_q <= S_IDLE;
          else if (!legal) begin
            err_q <= 1'b1;
            st_q  <= S_IDLE;
          end else st_q <= S_RD;
        end
        S_RD: st_q <= S_WR;
        S_WR: begin
          if (ctl_q.rem_m1 == '0) begin
            last_q <= 1'b1;
            st_q   <= S_WB;
          end else begin
            ctl_q.rem_m1 <= ctl_q.rem_m1 - 1'b1;
            if ((grp_q == grp_m1) || (!is_auto && !req_i)) st_q <= S_WB;
            else begin
              grp_q <= grp_q + 1'b1;
              st_q  <= S_RD;
            end
          end
        end
        S_WB: st_q <= (!last_q && is_auto) ? S_FSRC : S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    wb_word      = ctl_q;
    wb_word.mode = last_q ? MODE_STOP : ctl_q.mode;
  end

  always_comb begin
    mem_req_o   = 1'b1;
    mem_we_o    = 1'b0;
    mem_addr_o  = base_i;
    mem_size_o  = 2'd2;
    mem_wdata_o = '0;
    unique case (st_q)
      S_FSRC: mem_addr_o = base_i;
      S_FDST: mem_addr_o = base_i + AW'(4);
      S_FCTL: mem_addr_o = base_i + AW'(8);
      S_RD: begin
        mem_addr_o = side_addr[0];
        mem_size_o = ctl_q.ssize;
      end
      S_WR: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = side_addr[1];
        mem_size_o  = ctl_q.dsize;
        mem_wdata_o = mem_rdata_i;
      end
      S_WB: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = base_i + AW'(8);
        mem_wdata_o = DW'(wb_word);
      end
      default: mem_req_o = 1'b0;
    endcase
  end

  assign busy_o = (st_q != S_IDLE);
  assign done_o = (st_q == S_WB) && last_q;
  assign err_o  = err_q;

  // Final write-back carries mode stop to the control word slot
  a_r7_done_final_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (mem_req_o && mem_we_o && mem_addr_o == base_i + AW'(8) &&
                mem_wdata_o[2:0] == MODE_STOP));

  a_r7_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // Last write-back directly follows the last item write
  a_r3_wb_after_item: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_we_o));

  // Every access is aligned to its size (base_i assumed word aligned)
  a_r3_addr_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ((mem_size_o == 2'd0) ||
                   (mem_size_o == 2'd1 && mem_addr_o[0] == 1'b0) ||
                   (mem_size_o == 2'd2 && mem_addr_o[1:0] == 2'b00)));

  a_r6_group_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_q <= grp_m1);

  a_r8_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !mem_req_o);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !done_o));
endmodule

// File: tb/dma_desc_engine_test.sv
module dma_desc_engine_test;
  localparam logic [31:0] BASE = 32'h10;
  localparam logic [31:0] SRC  = 32'h400;
  localparam logic [31:0] DST  = 32'h800;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0;
  logic        busy, done, err, mreq, mwe;
  logic [31:0] maddr, mwdata;
  logic [31:0] mrdata = '0;
  logic [1:0]  msize;

  logic [7:0] mem [0:4095];
  logic [7:0] ex  [0:4095];
  int n_cmp = 0, n_bad = 0;
  int done_cnt = 0, wb_cnt = 0;

  always #4 clk = ~clk;

  dma_desc_engine #(.AW(32)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .base_i(BASE),
    .busy_o(busy), .done_o(done), .err_o(err),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_size_o(msize), .mem_wdata_o(mwdata), .mem_rdata_i(mrdata)
  );

  function automatic logic [31:0] rd(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] v = '0;
    for (int k = 0; k < 4; k++)
      if (k < (1 << sz)) v[8*k +: 8] = mem[12'(a + k)];
    return v;
  endfunction

  always @(posedge clk) begin
    if (mreq && !mwe) mrdata <= rd(maddr, msize);
    if (mreq && mwe) begin
      for (int k = 0; k < 4; k++)
        if (k < (1 << msize)) mem[12'(maddr + k)] <= mwdata[8*k +: 8];
      if (maddr == BASE + 8) wb_cnt <= wb_cnt + 1;
    end
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr32(input logic [31:0] a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) mem[12'(a + k)] = v[8*k +: 8];
  endtask

  function automatic logic [31:0] item_addr(input logic [31:0] e, input int inc,
                                             input int sz, input int rem_m1);
    logic [31:0] a = (inc == 3) ? e : e - (32'(rem_m1) << inc);
    return a & ~((32'd1 << sz) - 32'd1);
  endfunction

  task automatic run(input int mode, input int n, input int ssz, input int dsz,
                     input int sinc, input int dinc, input int arb,
                     input bit hold, input string tag);
    logic [31:0] se, de, ctl, exp_ctl, sa, da;
    int moved, wbs, g, d0, w0, q, miss;
    bit bad;
    for (int i = 0; i < 1024; i++) begin
      mem[12'(SRC + i)] = 8'($urandom);
      mem[12'(DST + i)] = 8'($urandom);
    end
    se  = (sinc == 3) ? SRC : SRC + (32'(n) << sinc) - 1;
    de  = (dinc == 3) ? DST : DST + (32'(n) << dinc) - 1;
    ctl = (32'(dinc) << 30) | (32'(dsz) << 28) | (32'(sinc) << 26) | (32'(ssz) << 24) |
          (32'(arb) << 14) | (32'(n - 1) << 4) | 32'(mode);
    wr32(BASE, se); wr32(BASE + 4, de); wr32(BASE + 8, ctl);
    for (int i = 0; i < 4096; i++) ex[i] = mem[i];
    bad = (mode != 0) && (mode > 2 || ssz == 3 || ssz != dsz ||
          (sinc != 3 && sinc < ssz) || (dinc != 3 && dinc < dsz));
    moved = (mode == 0 || bad) ? 0 : (mode == 1 && !hold) ? 1 : n;
    for (int i = 0; i < moved; i++) begin
      sa = item_addr(se, sinc, ssz, n - 1 - i);
      da = item_addr(de, dinc, dsz, n - 1 - i);
      for (int k = 0; k < (1 << ssz); k++) ex[12'(da + k)] = ex[12'(sa + k)];
    end
    g = 1 << ((arb > 10) ? 10 : arb);
    wbs = (moved == 0) ? 0 : (moved < n) ? 1 : (n + g - 1) / g;
    if (moved == 0) exp_ctl = ctl;
    else if (moved == n) exp_ctl = ctl & ~32'h3FF7;
    else exp_ctl = (ctl & ~32'h3FF0) | (32'(n - 1 - moved) << 4);
    d0 = done_cnt; w0 = wb_cnt;
    @(negedge clk) req = 1'b1;
    if (hold) begin
      while (done_cnt == d0) @(negedge clk);
      req = 1'b0;
    end else @(negedge clk) req = 1'b0;
    q = 0;
    while (q < 4) begin
      @(negedge clk);
      q = busy ? 0 : q + 1;
    end
    miss = 0;
    for (int i = 0; i < 1024; i++) if (mem[12'(DST + i)] !== ex[12'(DST + i)]) miss++;
    chk({tag, " dest bytes wrong"}, 32'(miss), 32'd0);
    chk("R8 err flag", {31'd0, err}, {31'd0, bad});
    chk("R7/R5 control word", rd(BASE + 8, 2), exp_ctl);
    chk("R6 write-back count", 32'(wb_cnt - w0), 32'(wbs));
    chk("R7 done pulses", 32'(done_cnt - d0), (moved == n && moved > 0) ? 32'd1 : 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R4 watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int unsigned s;
    s = $urandom(32'h5EED);
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'd0, busy}, 32'd0);
    chk("R1 mem_req in reset", {31'd0, mreq}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", {28'd0, busy, done, err, mreq}, 32'd0);

    run(2, 1, 0, 0, 0, 0, 0, 0, "R10 single item");
    run(2, 1024, 0, 0, 0, 0, 10, 0, "R10 full count");
    run(2, 5, 2, 2, 2, 2, 0, 0, "R6 group of one");
    run(2, 20, 1, 1, 1, 1, 15, 0, "R6 group clamp");
    run(2, 7, 1, 1, 1, 1, 1, 0, "R4 auto groups");
    run(2, 6, 2, 2, 3, 2, 2, 0, "R3 fixed source");
    run(2, 6, 1, 1, 1, 3, 2, 0, "R3 fixed dest");
    run(2, 8, 0, 0, 2, 1, 3, 0, "R3 byte items wide step");
    run(1, 6, 2, 2, 2, 2, 3, 0, "R5 basic pulse");
    run(1, 9, 0, 0, 0, 0, 1, 1, "R5 basic held");
    run(3, 4, 0, 0, 0, 0, 2, 0, "R8 pingpong mode");
    run(2, 4, 0, 0, 0, 0, 2, 0, "R8 err cleared");
    run(6, 4, 0, 0, 0, 0, 2, 0, "R8 gather mode");
    run(2, 4, 3, 3, 3, 3, 2, 0, "R8 size code 3");
    run(2, 4, 1, 2, 2, 2, 2, 0, "R8 size mismatch");
    run(2, 4, 2, 2, 1, 2, 2, 0, "R8 step below size");
    run(0, 4, 0, 0, 0, 0, 2, 0, "R9 stop mode");
    run(0, 4, 1, 2, 0, 0, 2, 0, "R9 stop ignores fields");

    for (int t = 0; t < 24; t++) begin
      int sz, si, di, md;
      sz = $urandom_range(2, 0);
      si = $urandom_range(3, sz);
      di = $urandom_range(3, sz);
      md = $urandom_range(2, 1);
      run(md, $urandom_range(40, 1), sz, sz, si, di, $urandom_range(11, 0),
          md == 1, "R2 random transfer");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule